// File: doc/BRIEF.md
# Rising-Edge Phase Aligner

This block is a cycle-based digital model of the loop that brings two divided clocks of equal frequency into rising-edge alignment. One input comes from a system clock divided by M. The other comes from a memory-side clock divided by N. The dividers are chosen so that both inputs run at the same rate; for example, dividing by 4 and by 3 can give 33 MHz on both. Both inputs are sampled by a fast system clock. Each one passes through its own two-flop synchronizer, and then only its rising edges are extracted.

For every pair of rising edges, a judge records which input rose first and how many sample cycles separate the two edges. A bang-bang controller then moves a delay-tap index by exactly one step toward alignment. The tap index stands in for a real delay line. A lock monitor counts consecutive comparisons whose error lies inside a programmable window. It raises a lock flag once that run is long enough. Falling edges never take part in a decision, so the two inputs may have different duty cycles. When an input is unused and held low, no comparison is made and the tap stays where it is.

Top module: `rise_phase_aligner`

## Requirements
- R1: After reset, `tap_sel` equals `TAP_RESET` (default 8 of 16 taps), and `locked`, `cmp_valid`, `err_mag` and `err_lead` are all 0.
- R2: A comparison pairs one rising edge of `ref_in` with the next rising edge of `fb_in`, in either order. `err_mag` reports the distance between the two edges in clock cycles. `err_lead` is 1 only when `ref_in` rose strictly first. Edges that arrive in the same cycle give `err_mag` = 0 and `err_lead` = 0.
- R3: The position of the falling edges, and therefore the duty cycle of each input (25% to 75%), has no effect on `err_mag`, `err_lead` or the tap.
- R4: When `align_en` = 1, every comparison in which `ref_in` led raises `tap_sel` by exactly 1, and every comparison in which `fb_in` led lowers it by exactly 1. A comparison with zero error leaves it unchanged.
- R5: `tap_sel` saturates. It stays at `N_TAPS-1` on further lead results and stays at 0 on further lag results.
- R6: When `align_en` = 0, `tap_sel` holds its value, while `err_mag`, `err_lead` and `locked` keep updating.
- R7: When both inputs are held low, no comparison is made and `tap_sel` holds its value. A lone rising edge whose partner does not arrive within `2^ERR_W - 1` cycles is discarded without any comparison.
- R8: `locked` rises on the comparison that completes `lock_need` consecutive comparisons with `err_mag <= lock_win`. A `lock_need` of 0 acts as 1.
- R9: The first comparison with `err_mag > lock_win` clears `locked` and restarts the consecutive count.
- R10: `cmp_valid` is high for exactly one cycle per completed comparison. It is high in the same cycle in which `err_mag` and `err_lead` take the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Divided system-side clock; its lead raises the tap |
| fb_in | input | 1 | Divided memory-side clock; its lead lowers the tap |
| align_en | input | 1 | 1 lets the tap move; 0 freezes it |
| lock_win | input | ERR_W | Largest error, in cycles, counted as in-window |
| lock_need | input | LOCK_W | Consecutive in-window comparisons needed for lock |
| tap_sel | output | TAP_W | Delay-tap index of the adjusted output |
| locked | output | 1 | Lock flag |
| cmp_valid | output | 1 | One-cycle pulse per completed comparison |
| err_mag | output | ERR_W | Edge-to-edge distance of the last comparison |
| err_lead | output | 1 | 1 when `ref_in` rose first in the last comparison |

## Verification
The case hardest to reach from the ports is a rising edge whose partner never arrives. If such a stale edge is not discarded, it pairs with an edge from a later period and produces a large, bogus correction. The stimulus drives a frame in which only one input toggles, keeps both inputs low long enough for the wait timeout to expire, and then checks that the tap has not moved and that no comparison pulse appeared. Random frames then vary the skew across plus and minus half a period and draw independent duty cycles for the two inputs. This shows that falling-edge skew never leaks into the result. Directed runs drive the tap into both saturation limits.

// File: rtl/pa_align_pkg.sv
package pa_align_pkg;
    typedef enum logic [1:0] {
        JUDGE_IDLE     = 2'd0,
        JUDGE_REF_WAIT = 2'd1,
        JUDGE_FB_WAIT  = 2'd2
    } judge_state_e;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1   = async_in;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign rise = sy_q.s2 & ~sy_q.prev;

    // a rising edge needs a low sample before it
    assert_rise_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pa_edge_judge.sv
module pa_edge_judge
    import pa_align_pkg::*;
#(
    parameter int ERR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_ref,
    input  logic             rise_fb,
    output logic             cmp_valid,
    output logic [ERR_W-1:0] err_mag,
    output logic             err_lead
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;
    localparam logic [ERR_W-1:0] CNT_ONE = ERR_W'(1);

    typedef struct packed {
        judge_state_e     st;
        logic [ERR_W-1:0] cnt;
        logic             vld;
        logic [ERR_W-1:0] mag;
        logic             lead;
    } judge_t;

    judge_t jg_d, jg_q;

    always_comb begin
        jg_d     = jg_q;
        jg_d.vld = 1'b0;
        unique case (jg_q.st)
            JUDGE_IDLE: begin
                if (rise_ref && rise_fb) begin
                    jg_d.vld  = 1'b1;
                    jg_d.mag  = '0;
                    jg_d.lead = 1'b0;
                end else if (rise_ref) begin
                    jg_d.st  = JUDGE_REF_WAIT;
                    jg_d.cnt = CNT_ONE;
                end else if (rise_fb) begin
                    jg_d.st  = JUDGE_FB_WAIT;
                    jg_d.cnt = CNT_ONE;
                end
            end
            JUDGE_REF_WAIT: begin
                if (rise_fb) begin
                    jg_d.vld  = 1'b1;
                    jg_d.mag  = jg_q.cnt;
                    jg_d.lead = 1'b1;
                    jg_d.st   = JUDGE_IDLE;
                end else if (rise_ref) begin
                    jg_d.cnt = CNT_ONE;
                end else if (jg_q.cnt == CNT_MAX) begin
                    jg_d.st = JUDGE_IDLE;
                end else begin
                    jg_d.cnt = jg_q.cnt + 1'b1;
                end
            end
            JUDGE_FB_WAIT: begin
                if (rise_ref) begin
                    jg_d.vld  = 1'b1;
                    jg_d.mag  = jg_q.cnt;
                    jg_d.lead = 1'b0;
                    jg_d.st   = JUDGE_IDLE;
                end else if (rise_fb) begin
                    jg_d.cnt = CNT_ONE;
                end else if (jg_q.cnt == CNT_MAX) begin
                    jg_d.st = JUDGE_IDLE;
                end else begin
                    jg_d.cnt = jg_q.cnt + 1'b1;
                end
            end
            default: jg_d.st = JUDGE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) jg_q <= '{st: JUDGE_IDLE, cnt: '0, vld: 1'b0, mag: '0, lead: 1'b0};
        else        jg_q <= jg_d;
    end

    assign cmp_valid = jg_q.vld;
    assign err_mag   = jg_q.mag;
    assign err_lead  = jg_q.lead;

    assert_result_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> $past(rise_ref || rise_fb));
    assert_lead_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && err_lead) |-> (err_mag != '0));
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> !cmp_valid);
    assert_result_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |-> ($stable(err_mag) && $stable(err_lead)));
endmodule

// File: rtl/pa_tap_ctrl.sv
module pa_tap_ctrl #(
    parameter int N_TAPS    = 16,
    parameter int TAP_W     = 4,
    parameter int TAP_RESET = 8,
    parameter int ERR_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic [ERR_W-1:0] err_mag,
    input  logic             err_lead,
    input  logic             align_en,
    output logic [TAP_W-1:0] tap_sel
);
    localparam logic [TAP_W-1:0] TAP_MAX  = TAP_W'(N_TAPS - 1);
    localparam logic [TAP_W-1:0] TAP_INIT = TAP_W'(TAP_RESET);

    typedef struct packed {
        logic [TAP_W-1:0] tap;
    } tap_t;

    tap_t tc_d, tc_q;
    logic step_up, step_dn;

    assign step_up = cmp_valid && align_en && err_lead;
    assign step_dn = cmp_valid && align_en && !err_lead && (err_mag != '0);

    always_comb begin
        tc_d = tc_q;
        if (step_up && (tc_q.tap != TAP_MAX))    tc_d.tap = tc_q.tap + 1'b1;
        else if (step_dn && (tc_q.tap != '0))    tc_d.tap = tc_q.tap - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tc_q <= '{tap: TAP_INIT};
        else        tc_q <= tc_d;
    end

    assign tap_sel = tc_q.tap;

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_sel != $past(tap_sel)) |->
            ((tap_sel == $past(tap_sel) + 1'b1) || (tap_sel == $past(tap_sel) - 1'b1)));
    assert_hold_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up || step_dn) |=> $stable(tap_sel));
    assert_sat_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && tap_sel == TAP_MAX) |=> (tap_sel == TAP_MAX));
    assert_sat_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && tap_sel == '0) |=> (tap_sel == '0));
    assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel <= TAP_MAX);
endmodule

// File: rtl/pa_lock_mon.sv
module pa_lock_mon #(
    parameter int ERR_W  = 5,
    parameter int LOCK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [ERR_W-1:0]  err_mag,
    input  logic [ERR_W-1:0]  lock_win,
    input  logic [LOCK_W-1:0] lock_need,
    output logic              locked
);
    localparam logic [LOCK_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic [LOCK_W-1:0] run;
        logic              lock;
    } lock_t;

    lock_t lk_d, lk_q;
    logic  in_win;

    assign in_win = (err_mag <= lock_win);

    always_comb begin
        lk_d = lk_q;
        if (cmp_valid) begin
            if (in_win) begin
                lk_d.run  = (lk_q.run == RUN_MAX) ? lk_q.run : lk_q.run + 1'b1;
                lk_d.lock = (lk_d.run >= lock_need);
            end else begin
                lk_d.run  = '0;
                lk_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign locked = lk_q.lock;

    assert_drop_on_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !in_win) |=> !locked);
    assert_lock_only_on_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(locked));
    assert_rise_after_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cmp_valid && in_win));
endmodule

// File: rtl/rise_phase_aligner.sv
module rise_phase_aligner #(
    parameter int N_TAPS    = 16,
    parameter int TAP_RESET = N_TAPS / 2,
    parameter int ERR_W     = 5,
    parameter int LOCK_W    = 4,
    localparam int TAP_W    = (N_TAPS > 1) ? $clog2(N_TAPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              fb_in,
    input  logic              align_en,
    input  logic [ERR_W-1:0]  lock_win,
    input  logic [LOCK_W-1:0] lock_need,
    output logic [TAP_W-1:0]  tap_sel,
    output logic              locked,
    output logic              cmp_valid,
    output logic [ERR_W-1:0]  err_mag,
    output logic              err_lead
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise_in;

    assign raw_in = {fb_in, ref_in};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
        pa_sync_edge u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[gi]),
            .rise     (rise_in[gi])
        );
    end

    pa_edge_judge #(.ERR_W(ERR_W)) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_ref  (rise_in[0]),
        .rise_fb   (rise_in[1]),
        .cmp_valid (cmp_valid),
        .err_mag   (err_mag),
        .err_lead  (err_lead)
    );

    pa_tap_ctrl #(
        .N_TAPS    (N_TAPS),
        .TAP_W     (TAP_W),
        .TAP_RESET (TAP_RESET),
        .ERR_W     (ERR_W)
    ) u_tap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .err_mag   (err_mag),
        .err_lead  (err_lead),
        .align_en  (align_en),
        .tap_sel   (tap_sel)
    );

    pa_lock_mon #(.ERR_W(ERR_W), .LOCK_W(LOCK_W)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .err_mag   (err_mag),
        .lock_win  (lock_win),
        .lock_need (lock_need),
        .locked    (locked)
    );

    assert_frozen_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !align_en |=> $stable(tap_sel));
endmodule

// File: tb/test_rise_phase_aligner.sv
`timescale 1ns/1ps
module test_rise_phase_aligner;
    localparam int N_TAPS = 16;
    localparam int TAP_RESET = 8;
    localparam int ERR_W = 5;
    localparam int LOCK_W = 4;
    localparam int FRAME = 40;
    localparam int START = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, fb_in = 1'b0, align_en = 1'b1;
    logic [ERR_W-1:0] lock_win = '0;
    logic [LOCK_W-1:0] lock_need = '0;
    logic [3:0] tap_sel;
    logic locked, cmp_valid, err_lead;
    logic [ERR_W-1:0] err_mag;

    int n_run = 0, n_fail = 0, pulses = 0;
    int m_tap = TAP_RESET, m_run = 0, m_lock = 0;

    always #2.5 clk = ~clk;

    rise_phase_aligner #(.N_TAPS(N_TAPS), .TAP_RESET(TAP_RESET), .ERR_W(ERR_W), .LOCK_W(LOCK_W))
    i_rise_phase_aligner (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .align_en(align_en),
        .lock_win(lock_win), .lock_need(lock_need), .tap_sel(tap_sel), .locked(locked),
        .cmp_valid(cmp_valid), .err_mag(err_mag), .err_lead(err_lead)
    );

    always @(negedge clk) if (rst_n && cmp_valid) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp_tap(input int t);
        if (t < 0) return 0;
        if (t > N_TAPS - 1) return N_TAPS - 1;
        return t;
    endfunction

    // d > 0: ref_in rises d cycles before fb_in
    task automatic frame(input int d, input int hr, input int hf, input string req);
        int mag, need;
        pulses = 0;
        for (int t = 0; t < FRAME; t++) begin
            @(negedge clk);
            ref_in = (t >= START && t < START + hr);
            fb_in  = (t >= START + d && t < START + d + hf);
        end
        mag = (d < 0) ? -d : d;
        if (align_en) m_tap = clamp_tap(m_tap + ((d > 0) ? 1 : (d < 0) ? -1 : 0));
        need = (int'(lock_need) == 0) ? 1 : int'(lock_need);
        if (mag <= int'(lock_win)) begin
            m_run = (m_run < 15) ? m_run + 1 : 15;
            m_lock = (m_run >= need) ? 1 : 0;
        end else begin
            m_run = 0;
            m_lock = 0;
        end
        chk({req, " err_mag"}, int'(err_mag), mag);
        chk({req, " err_lead"}, int'(err_lead), (d > 0) ? 1 : 0);
        chk({req, " tap"}, int'(tap_sel), m_tap);
        chk({req, " locked"}, int'(locked), m_lock);
        chk({req, " R10 pulses"}, pulses, 1);
    endtask

    task automatic lone(input bit use_ref);
        pulses = 0;
        for (int t = 0; t < 2 * FRAME; t++) begin
            @(negedge clk);
            ref_in = use_ref && (t >= START && t < START + 8);
            fb_in  = !use_ref && (t >= START && t < START + 8);
        end
        chk("R7 lone edge tap", int'(tap_sel), m_tap);
        chk("R7 lone edge no compare", pulses, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 reset tap", int'(tap_sel), TAP_RESET);
        chk("R1 reset locked", int'(locked), 0);
        chk("R1 reset err_mag", int'(err_mag), 0);
        chk("R1 reset cmp_valid", int'(cmp_valid), 0);
        rst_n = 1'b1;
        lock_win = 5'd2;
        lock_need = 4'd3;

        // R2 R3: coincident edges, very different duty
        frame(0, 5, 15, "R3 coincident");
        frame(4, 15, 5, "R2 ref leads");
        frame(-4, 5, 15, "R2 fb leads");
        // R8 R9 lock run
        frame(1, 10, 10, "R8 hit1");
        frame(-1, 7, 12, "R8 hit2");
        frame(2, 12, 6, "R8 hit3 locks");
        frame(0, 9, 9, "R8 stays");
        frame(5, 10, 10, "R9 miss unlocks");
        frame(1, 10, 10, "R9 restart");
        // R8 lock_need 0 acts as one
        lock_need = 4'd0;
        frame(-2, 8, 8, "R8 need zero");
        lock_need = 4'd3;
        // R5 saturation
        for (int i = 0; i < 12; i++) frame(3, 10, 10, "R5 up sat");
        chk("R5 top", int'(tap_sel), N_TAPS - 1);
        for (int i = 0; i < 20; i++) frame(-9, 6, 14, "R5 down sat");
        chk("R5 bottom", int'(tap_sel), 0);
        frame(9, 14, 6, "R4 leaves bottom");
        // R6 frozen
        align_en = 1'b0;
        frame(6, 10, 10, "R6 frozen up");
        frame(-6, 10, 10, "R6 frozen down");
        align_en = 1'b1;
        // R7 idle and lone edges
        pulses = 0;
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (200) @(negedge clk);
        chk("R7 idle tap", int'(tap_sel), m_tap);
        chk("R7 idle no compare", pulses, 0);
        lone(1'b1);
        lone(1'b0);
        frame(2, 10, 10, "R7 after lone");
        // random mix
        for (int i = 0; i < 80; i++) begin
            int d, hr, hf;
            d  = int'($urandom_range(18)) - 9;
            hr = 5 + int'($urandom_range(10));
            hf = 5 + int'($urandom_range(10));
            align_en = ($urandom_range(7) != 0);
            lock_win = ERR_W'($urandom_range(4));
            frame(d, hr, hf, "R4 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule